// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of a three-wire control port that a baseband processor uses to set up a radio transceiver. The host pulls an active-low select, toggles a serial clock and shifts a 24-bit frame on a single data line. The frame carries a read/write flag, a 5-bit register address and an 18-bit payload. The block holds a bank of 18-bit configuration registers and drives all of them out on a flat bus toward the analog and synthesizer logic. The same data line carries register contents back to the host during a read.

The select, clock and data inputs are oversampled on the core clock through a synchronizer of parameterised depth. All shifting, committing and turnaround decisions happen on the detected edges. The bidirectional pin is split into an input, an output and an output enable, and the pad ring ties them together. Two actions take effect when a frame ends. A write to the all-ones address returns every register to its power-on value when select rises. A write to any synthesizer register raises a recalibration strobe, which stays high until select rises and never lasts less than a programmed number of core cycles.

Top module: `cfgSerialPort`

## Requirements
- R1: A frame is sent most significant bit first on rising serial clock edges: bit 1 is the R/W flag (1 = read, 0 = write), bits 2..6 are the address and bits 7..24 are the 18-bit data. A write stores the data in the addressed register. Register k appears on `cfgBus[18k+17:18k]`.
- R2: A write commits on the falling serial clock edge that follows the 24th rising edge. After the 24th rising edge and before that falling edge, the register still holds its old value.
- R3: If select rises before the 24th data clock, the addressed register keeps its previous value.
- R4: In a read frame, `sdiOe` goes high after the falling clock edge that follows the 6th rising edge. `sdiOut` then presents the addressed register MSB first, one bit per clock, so that the host samples bit 17 on the 7th rising edge and bit 0 on the 24th rising edge.
- R5: `sdiOe` is low out of reset and throughout write frames. It drops in the same cycle that `selN` goes high.
- R6: Reset values are: reg0 = 0x00007, reg1 = 0x09003, reg2 = 0x00022, reg3 = 0x1FF78, reg4 = 0x09003, reg5 = 0x01780, reg7 = 0x14578, reg8 = 0x1E742, reg9 = 0x00120, and every other register is 0.
- R7: A write to address 31 (data ignored) leaves every register unchanged while select stays low. When select rises, all registers return to their R6 values.
- R8: A write to addresses 1 through 7 raises `recalStrobe` after the commit. It stays high while select remains low, falls after select rises, and is high for at least RECAL_MIN_CYC (default 16) core cycles. Writes to other addresses never raise it.
- R9: Addresses 13 to 30 are unimplemented. A read of one of them returns 0, and a write to one of them changes no register.
- R10: Serial clocks beyond the 24th in a frame have no effect. The committed value is the one carried by data bits 7..24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to oversample the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdiIn | input | 1 | Data line, input side |
| sdiOut | output | 1 | Data line, output side during reads |
| sdiOe | output | 1 | Output enable for the data line pad |
| cfgBus | output | NUM_REGS*18 | All configuration registers, register k at bits 18k+17:18k |
| recalStrobe | output | 1 | Synthesizer recalibration pulse |

## Verification
A wrong bit count or a wrong frame boundary shows up on `cfgBus` within a few core cycles of the final falling clock edge. Such a fault either commits too early, which the bench checks between the last rising and the last falling edge, or stores a shifted payload. A stale read shift register or a late turnaround corrupts the first read bit the host samples on its 7th clock. A stuck reset-pending or recalibration state becomes visible only when select rises. For that reason the bench checks the bus and the strobe both before and after that edge.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int DATA_W = 18;
  localparam int ADDR_W = 5;

  typedef struct packed {
    logic sampleBit;
    logic loadRead;
    logic shiftRead;
    logic commitWr;
    logic selRise;
  } portCtl_t;

  // power-on contents of each implemented register
  function automatic logic [DATA_W-1:0] regDefault(input int idx);
    case (idx)
      0:       return 18'h00007;
      1:       return 18'h09003;
      2:       return 18'h00022;
      3:       return 18'h1FF78;
      4:       return 18'h09003;
      5:       return 18'h01780;
      7:       return 18'h14578;
      8:       return 18'h1E742;
      9:       return 18'h00120;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfgPortCtrl.sv
module cfgPortCtrl
  import regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HDR_BITS    = 1 + ADDR_W,
  parameter int FRAME_BITS  = 1 + ADDR_W + DATA_W
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     selN,
  input  logic     sclk,
  input  logic     sdiIn,
  output logic     sdiSync,
  output portCtl_t ctl,
  output logic     oeReg
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] HDR_CNT   = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] SAT_CNT   = CNT_W'(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] selPipe, sclkPipe, sdiPipe;
  logic selS, sclkS, selPrev, sclkPrev;
  logic rwFlag, riseEdge, fallEdge;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPipe  <= '1;
      sclkPipe <= '0;
      sdiPipe  <= '0;
      selPrev  <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      selPipe[0]  <= selN;
      sclkPipe[0] <= sclk;
      sdiPipe[0]  <= sdiIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        selPipe[i]  <= selPipe[i-1];
        sclkPipe[i] <= sclkPipe[i-1];
        sdiPipe[i]  <= sdiPipe[i-1];
      end
      selPrev  <= selS;
      sclkPrev <= sclkS;
    end
  end

  assign selS     = selPipe[SYNC_STAGES-1];
  assign sclkS    = sclkPipe[SYNC_STAGES-1];
  assign sdiSync  = sdiPipe[SYNC_STAGES-1];
  assign riseEdge = sclkS & ~sclkPrev & ~selS;
  assign fallEdge = ~sclkS & sclkPrev & ~selS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rwFlag <= 1'b0;
      oeReg  <= 1'b0;
    end else if (selS) begin
      bitCnt <= '0;
      oeReg  <= 1'b0;
    end else begin
      if (riseEdge && bitCnt != SAT_CNT) bitCnt <= bitCnt + 1'b1;
      if (riseEdge && bitCnt == '0) rwFlag <= sdiSync;
      if (ctl.loadRead) oeReg <= 1'b1;
    end
  end

  always_comb begin
    ctl.sampleBit = riseEdge && (bitCnt < FRAME_CNT);
    ctl.loadRead  = fallEdge && rwFlag && (bitCnt == HDR_CNT);
    ctl.shiftRead = fallEdge && rwFlag && (bitCnt > HDR_CNT) && (bitCnt <= FRAME_CNT);
    ctl.commitWr  = fallEdge && !rwFlag && (bitCnt == FRAME_CNT);
    ctl.selRise   = selS & ~selPrev;
  end

  // R4
  oe_read_chk: assert property (@(posedge clk) disable iff (!rstN) oeReg |-> rwFlag);
  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN) bitCnt <= SAT_CNT);
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.sampleBit, ctl.commitWr, ctl.loadRead, ctl.selRise}));
endmodule

// File: rtl/cfgPortData.sv
module cfgPortData
  import regport_pkg::*;
#(
  parameter int NUM_REGS      = 13,
  parameter int RECAL_MIN_CYC = 16,
  parameter int PLL_FIRST     = 1,
  parameter int PLL_LAST      = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  portCtl_t                   ctl,
  input  logic                       sdiSync,
  output logic [NUM_REGS*DATA_W-1:0] regFlat,
  output logic                       readBit,
  output logic                       recalStrobe
);
  localparam int SHIFT_W = ADDR_W + DATA_W;
  localparam int RC_W    = $clog2(RECAL_MIN_CYC + 1);
  localparam logic [ADDR_W-1:0] GRST_ADDR = '1;
  localparam logic [ADDR_W-1:0] NREG_A    = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] PLL_LO_A  = ADDR_W'(PLL_FIRST);
  localparam logic [ADDR_W-1:0] PLL_HI_A  = ADDR_W'(PLL_LAST);
  localparam logic [RC_W-1:0]   RC_LAST   = RC_W'(RECAL_MIN_CYC - 1);

  logic [SHIFT_W-1:0] frameShift;
  logic [DATA_W-1:0]  regs [NUM_REGS];
  logic [DATA_W-1:0]  readShift, rdValue, wrData;
  logic [ADDR_W-1:0]  wrAddr, rdAddr;
  logic rstPending, pllHit, selSeen;
  logic [RC_W-1:0] recalCnt;

  assign wrAddr = frameShift[DATA_W +: ADDR_W];
  assign wrData = frameShift[DATA_W-1:0];
  assign rdAddr = frameShift[ADDR_W-1:0];
  assign pllHit = ctl.commitWr && wrAddr >= PLL_LO_A && wrAddr <= PLL_HI_A;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameShift <= '0;
    else if (ctl.sampleBit) frameShift <= {frameShift[SHIFT_W-2:0], sdiSync};
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regs[g] <= regDefault(g);
      else if (ctl.selRise && rstPending) regs[g] <= regDefault(g);
      else if (ctl.commitWr && wrAddr == ADDR_W'(g)) regs[g] <= wrData;
    end
    assign regFlat[g*DATA_W +: DATA_W] = regs[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPending <= 1'b0;
    else if (ctl.selRise) rstPending <= 1'b0;
    else if (ctl.commitWr && wrAddr == GRST_ADDR) rstPending <= 1'b1;
  end

  always_comb begin
    rdValue = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rdAddr == ADDR_W'(i)) rdValue = regs[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readShift <= '0;
    else if (ctl.loadRead) readShift <= rdValue;
    else if (ctl.shiftRead) readShift <= {readShift[DATA_W-2:0], 1'b0};
  end
  assign readBit = readShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recalStrobe <= 1'b0;
      recalCnt    <= '0;
      selSeen     <= 1'b0;
    end else if (pllHit) begin
      recalStrobe <= 1'b1;
      recalCnt    <= '0;
      selSeen     <= 1'b0;
    end else if (recalStrobe) begin
      if (recalCnt != RC_LAST) recalCnt <= recalCnt + 1'b1;
      if (ctl.selRise) selSeen <= 1'b1;
      if ((selSeen || ctl.selRise) && recalCnt == RC_LAST) recalStrobe <= 1'b0;
    end
  end

  // R7
  grst_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.selRise && rstPending) |=> (regs[0] == regDefault(0)));
  // R8
  recal_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recalStrobe) |-> $past(ctl.commitWr));
  // R8
  recal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recalStrobe) |=> recalStrobe);
  // R9
  ignore_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commitWr && wrAddr >= NREG_A && wrAddr != GRST_ADDR) |=> $stable(regFlat));
endmodule

// File: rtl/cfgSerialPort.sv
module cfgSerialPort
  import regport_pkg::*;
#(
  parameter int NUM_REGS      = 13,
  parameter int SYNC_STAGES   = 2,
  parameter int RECAL_MIN_CYC = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       selN,
  input  logic                       sclk,
  input  logic                       sdiIn,
  output logic                       sdiOut,
  output logic                       sdiOe,
  output logic [NUM_REGS*DATA_W-1:0] cfgBus,
  output logic                       recalStrobe
);
  portCtl_t ctl;
  logic sdiSync, oeReg;

  cfgPortCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdiIn(sdiIn),
    .sdiSync(sdiSync), .ctl(ctl), .oeReg(oeReg)
  );

  cfgPortData #(.NUM_REGS(NUM_REGS), .RECAL_MIN_CYC(RECAL_MIN_CYC)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdiSync(sdiSync),
    .regFlat(cfgBus), .readBit(sdiOut), .recalStrobe(recalStrobe)
  );

  // the raw select releases the pad without synchronizer delay
  assign sdiOe = oeReg & ~selN;
endmodule

// File: tb/tb_cfgSerialPort.sv
module tb_cfgSerialPort;
  localparam int NREG = 13;
  localparam int HALF = 8;
  localparam int RMIN = 16;

  logic clk = 1'b0, rstN = 1'b0, selN = 1'b1, sclk = 1'b0, sdiIn = 1'b0;
  logic sdiOut, sdiOe, recalStrobe;
  logic [NREG*18-1:0] cfgBus;
  int tests = 0, fails = 0;
  int recalHi = 0, recalRises = 0;
  logic recalPrev = 1'b0;

  cfgSerialPort dut (.clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdiIn(sdiIn),
    .sdiOut(sdiOut), .sdiOe(sdiOe), .cfgBus(cfgBus), .recalStrobe(recalStrobe));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (recalStrobe) recalHi++;
    if (recalStrobe && !recalPrev) recalRises++;
    recalPrev <= recalStrobe;
  end

  function automatic logic [17:0] getReg(input int k);
    return cfgBus[k*18 +: 18];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit; returns the data line and enable seen just before the rise
  task automatic sendBit(input logic b, output logic obit, output logic oe);
    @(negedge clk) sdiIn = b;
    waitN(HALF);
    obit = sdiOut;
    oe = sdiOe;
    sclk = 1'b1;
    waitN(HALF);
    sclk = 1'b0;
  endtask

  task automatic frame(input logic rw, input logic [4:0] addr, input logic [17:0] data,
                       input int nbits, output logic [17:0] rd, output logic oeOk);
    logic [23:0] word;
    logic ob, oe;
    word = {rw, addr, data};
    rd = '0;
    oeOk = 1'b1;
    @(negedge clk) selN = 1'b0;
    waitN(HALF);
    for (int i = 0; i < nbits; i++) begin
      sendBit((i < 24) ? word[23-i] : 1'b1, ob, oe);
      if (i >= 6 && i < 24 && rw) rd[23-i] = ob;
      if (oe !== ((rw && i >= 6 && i < 24) ? 1'b1 : 1'b0)) oeOk = 1'b0;
    end
    waitN(HALF);
    selN = 1'b1;
    waitN(2*HALF);
  endtask

  task automatic wr(input logic [4:0] a, input logic [17:0] d);
    logic [17:0] rd; logic ok;
    frame(1'b0, a, d, 24, rd, ok);
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [17:0] d, output logic ok);
    frame(1'b1, a, 18'h0, 24, d, ok);
  endtask

  task automatic t_reset();
    // R6
    chk("R6 reg0", getReg(0), 18'h00007);
    chk("R6 reg1", getReg(1), 18'h09003);
    chk("R6 reg2", getReg(2), 18'h00022);
    chk("R6 reg3", getReg(3), 18'h1FF78);
    chk("R6 reg4", getReg(4), 18'h09003);
    chk("R6 reg5", getReg(5), 18'h01780);
    chk("R6 reg6", getReg(6), 18'h00000);
    chk("R6 reg7", getReg(7), 18'h14578);
    chk("R6 reg8", getReg(8), 18'h1E742);
    chk("R6 reg9", getReg(9), 18'h00120);
    chk("R6 reg12", getReg(12), 18'h00000);
    // R5
    chk("R5 oe after reset", sdiOe, 1'b0);
    chk("R8 strobe after reset", recalStrobe, 1'b0);
  endtask

  task automatic t_writeRead();
    logic [17:0] d; logic ok, okw;
    logic [17:0] rdd;
    frame(1'b0, 5'd9, 18'h2A5C3, 24, rdd, okw);
    chk("R1 write reg9", getReg(9), 18'h2A5C3);
    chk("R5 oe low in write", okw, 1'b1);
    rdReg(5'd9, d, ok);
    chk("R4 read reg9", d, 18'h2A5C3);
    chk("R4 oe window", ok, 1'b1);
    wr(5'd11, 18'h15A3C);
    chk("R1 write reg11", getReg(11), 18'h15A3C);
    rdReg(5'd11, d, ok);
    chk("R4 read reg11", d, 18'h15A3C);
    rdReg(5'd2, d, ok);
    chk("R4 read default reg2", d, 18'h00022);
  endtask

  task automatic t_commitEdge();
    logic [23:0] word; logic ob, oe;
    word = {1'b0, 5'd10, 18'h3C0F1};
    @(negedge clk) selN = 1'b0;
    waitN(HALF);
    for (int i = 0; i < 23; i++) sendBit(word[23-i], ob, oe);
    @(negedge clk) sdiIn = word[0];
    waitN(HALF);
    sclk = 1'b1;
    waitN(2*HALF);
    // R2
    chk("R2 no commit before fall", getReg(10), 18'h00000);
    sclk = 1'b0;
    waitN(2*HALF);
    chk("R2 commit after fall", getReg(10), 18'h3C0F1);
    selN = 1'b1;
    waitN(2*HALF);
  endtask

  task automatic t_abort();
    logic [17:0] rd; logic ok;
    frame(1'b0, 5'd10, 18'h00001, 20, rd, ok);
    // R3
    chk("R3 aborted write", getReg(10), 18'h3C0F1);
    frame(1'b0, 5'd10, 18'h11111, 23, rd, ok);
    chk("R3 aborted at bit 23", getReg(10), 18'h3C0F1);
  endtask

  task automatic t_oeRelease();
    logic [23:0] word; logic ob, oe;
    word = {1'b1, 5'd9, 18'h0};
    @(negedge clk) selN = 1'b0;
    waitN(HALF);
    for (int i = 0; i < 10; i++) sendBit(word[23-i], ob, oe);
    waitN(HALF);
    chk("R5 oe high mid read", sdiOe, 1'b1);
    @(negedge clk) selN = 1'b1;
    #1;
    // R5
    chk("R5 oe drops with select", sdiOe, 1'b0);
    waitN(2*HALF);
  endtask

  task automatic t_globalReset();
    logic [23:0] word; logic ob, oe;
    wr(5'd2, 18'h3ABCD);
    chk("R1 write reg2", getReg(2), 18'h3ABCD);
    word = {1'b0, 5'd31, 18'h2AAAA};
    @(negedge clk) selN = 1'b0;
    waitN(HALF);
    for (int i = 0; i < 24; i++) sendBit(word[23-i], ob, oe);
    waitN(4*HALF);
    // R7
    chk("R7 reset deferred reg2", getReg(2), 18'h3ABCD);
    chk("R7 reset deferred reg9", getReg(9), 18'h2A5C3);
    selN = 1'b1;
    waitN(2*HALF);
    chk("R7 reset applied reg2", getReg(2), 18'h00022);
    chk("R7 reset applied reg9", getReg(9), 18'h00120);
    chk("R7 reset applied reg11", getReg(11), 18'h00000);
  endtask

  task automatic t_recal();
    logic [23:0] word; logic ob, oe;
    recalRises = 0;
    wr(5'd0, 18'h00003);
    wr(5'd8, 18'h00123);
    waitN(40);
    // R8
    chk("R8 no strobe for reg0/reg8", recalRises, 0);
    recalHi = 0; recalRises = 0;
    wr(5'd3, 18'h1FF70);
    waitN(40);
    chk("R8 strobe once for reg3", recalRises, 1);
    chk("R8 min width", (recalHi >= RMIN) ? 1 : 0, 1);
    recalHi = 0; recalRises = 0;
    word = {1'b0, 5'd5, 18'h01800};
    @(negedge clk) selN = 1'b0;
    waitN(HALF);
    for (int i = 0; i < 24; i++) sendBit(word[23-i], ob, oe);
    waitN(60);
    chk("R8 strobe held while selected", recalStrobe, 1'b1);
    selN = 1'b1;
    waitN(30);
    chk("R8 strobe falls after select", recalStrobe, 1'b0);
    chk("R8 held width", (recalHi >= 60) ? 1 : 0, 1);
    chk("R1 write reg5", getReg(5), 18'h01800);
  endtask

  task automatic t_unimpl();
    logic [NREG*18-1:0] snap; logic [17:0] d; logic ok;
    snap = cfgBus;
    wr(5'd20, 18'h3FFFF);
    // R9
    chk("R9 write ignored", (cfgBus === snap) ? 1 : 0, 1);
    rdReg(5'd20, d, ok);
    chk("R9 read addr20", d, 18'h0);
    rdReg(5'd13, d, ok);
    chk("R9 read addr13", d, 18'h0);
  endtask

  task automatic t_extraClocks();
    logic [17:0] rd; logic ok;
    frame(1'b0, 5'd12, 18'h0A5A5, 27, rd, ok);
    // R10
    chk("R10 extra clocks ignored", getReg(12), 18'h0A5A5);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    waitN(4);
    t_reset();
    t_writeRead();
    t_commitEdge();
    t_abort();
    t_oeRelease();
    t_globalReset();
    t_recal();
    t_unimpl();
    t_extraClocks();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule